// File: doc/BRIEF.md
# Key Input Conditioner with Hold-to-Reset Detector

This block conditions four key inputs that run on a 32.768 kHz clock. Each key is first passed through a two-flop synchronizer. After that, the key level used for interrupts comes from one of two sources, chosen by a static enable:

- **Direct path.** The synchronized level is used as it is, for the fastest response.
- **Filtered path.** The level is sampled once every eight clocks (4096 Hz). It only moves to a new value after two consecutive samples agree, which removes contact bounce and short noise spikes.

A rising edge on the chosen level produces a one-cycle interrupt pulse for that key.

Alongside the interrupt path, a combination detector watches the synchronized keys and raises a system reset request. This happens when every key in a selected group has been held high together for a programmable hold time, 2 s by default. A static select chooses the group or disables the detector. The request stays high while the group is held and drops as soon as any key in the group is let go.

Top module: `keyin_cond`

## Requirements
- R1: While `rstN` is low and on the first cycle after, `keyLevel`, `keyIrq` and `rstReq` are all zero.
- R2: With `filtEn` = 0, a key change driven before clock edge n appears on `keyLevel` after edge n+1, two edges later.
- R3: `keyIrq[i]` pulses high for exactly one cycle, in the cycle where `keyLevel[i]` first reads 1; a falling level produces no pulse.
- R4: With `filtEn` = 1, `keyLevel` changes only on a sample strobe every SAMPLE_DIV clocks. A steady new key value appears no sooner than SAMPLE_DIV+3 edges and no later than 2*SAMPLE_DIV+2 edges after it is driven.
- R5: With `filtEn` = 1, a key pulse shorter than SAMPLE_DIV cycles changes neither `keyLevel` nor `keyIrq`.
- R6: `comboSel` selects the reset group, with keys given by their `keyRaw` bit indices: 1 = bits 0,1; 2 = bits 0..2; 3 = bits 0..3. Keys outside the group do not matter.
- R7: With `comboSel` = 0, no key pattern ever raises `rstReq`.
- R8: When a full group is driven before edge n and then held, `rstReq` is first high after edge n+HOLD_CYCLES+1 and low before that.
- R9: Dropping any group key before the hold time has elapsed restarts the full hold time.
- R10: `rstReq` stays high while the group is held. It reads low two edges after any group key is released.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | 32.768 kHz system clock |
| rstN | input | 1 | Asynchronous active-low reset |
| keyRaw | input | 4 | Raw key inputs, bit i = key i |
| filtEn | input | 1 | 1 selects the sampled noise filter for the interrupt path |
| comboSel | input | 2 | Reset group select: 0 off, 1 keys 0-1, 2 keys 0-2, 3 keys 0-3 |
| keyLevel | output | 4 | Conditioned key levels |
| keyIrq | output | 4 | One-cycle rising-edge interrupt requests |
| rstReq | output | 1 | System reset request from a held key group |

## Verification
The assertions take `filtEn` and `comboSel` to be static settings. They assume that neither setting changes while a key is high or a filtered level is still settling. Under that assumption, a change of path cannot fake an edge, and the "level holds between strobes" property applies only once the filter has been enabled for a full cycle.

The stimulus follows this rule: it rewrites the configuration only after all keys have been low long enough for both paths to read zero. It drives keys on the falling clock edge so that every input is cleanly synchronized.

// File: rtl/keyin_pkg.sv
package keyin_pkg;

  localparam int KEY_COUNT = 4;

  typedef enum logic [1:0] {
    GRP_NONE = 2'd0,
    GRP_PAIR = 2'd1,
    GRP_TRIO = 2'd2,
    GRP_ALL  = 2'd3
  } grpSel_t;

  typedef struct packed {
    logic sampleTick;
    logic useFilter;
  } keyStrobes_t;

  function automatic logic [KEY_COUNT-1:0] grpMask(input grpSel_t sel);
    case (sel)
      GRP_PAIR: grpMask = 4'b0011;
      GRP_TRIO: grpMask = 4'b0111;
      GRP_ALL:  grpMask = 4'b1111;
      default:  grpMask = 4'b0000;
    endcase
  endfunction

endpackage

// File: rtl/keyin_datapath.sv
module keyin_datapath
  import keyin_pkg::*;
(
  input  logic                 clk,
  input  logic                 rstN,
  input  logic [KEY_COUNT-1:0] keyRaw,
  input  keyStrobes_t          strobes,
  input  grpSel_t              grpSel,
  output logic [KEY_COUNT-1:0] keyLevel,
  output logic [KEY_COUNT-1:0] keyIrq,
  output logic                 comboHit
);

  logic [KEY_COUNT-1:0] syncA, syncB;
  logic [KEY_COUNT-1:0] sampPrev, filtLvl;
  logic [KEY_COUNT-1:0] lastLvl;
  logic [KEY_COUNT-1:0] selMask;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      syncA <= '0;
      syncB <= '0;
    end else begin
      syncA <= keyRaw;
      syncB <= syncA;
    end
  end

  for (genvar g = 0; g < KEY_COUNT; g++) begin : gFilt
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        sampPrev[g] <= 1'b0;
        filtLvl[g]  <= 1'b0;
      end else if (strobes.sampleTick) begin
        sampPrev[g] <= syncB[g];
        if (syncB[g] == sampPrev[g]) filtLvl[g] <= syncB[g];
      end
    end
  end

  assign keyLevel = strobes.useFilter ? filtLvl : syncB;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) lastLvl <= '0;
    else       lastLvl <= keyLevel;
  end

  assign keyIrq   = keyLevel & ~lastLvl;
  assign selMask  = grpMask(grpSel);
  assign comboHit = (selMask != '0) && ((syncB & selMask) == selMask);

endmodule

// File: rtl/keyin_control.sv
module keyin_control
  import keyin_pkg::*;
#(
  parameter int SAMPLE_DIV  = 8,
  parameter int HOLD_CYCLES = 65536
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        filtEn,
  input  logic        comboHit,
  output keyStrobes_t strobes,
  output logic        rstReq
);

  localparam int DIV_W  = (SAMPLE_DIV > 1) ? $clog2(SAMPLE_DIV) : 1;
  localparam int HOLD_W = $clog2(HOLD_CYCLES + 1);
  localparam logic [DIV_W-1:0]  DIV_LAST   = DIV_W'(SAMPLE_DIV - 1);
  localparam logic [HOLD_W-1:0] HOLD_LIMIT = HOLD_W'(HOLD_CYCLES);

  logic [DIV_W-1:0]  divCnt;
  logic [HOLD_W-1:0] holdCnt;
  logic              divWrap;
  logic              atLimit;

  assign divWrap = (divCnt == DIV_LAST);
  assign atLimit = (holdCnt == HOLD_LIMIT);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)        divCnt <= '0;
    else if (divWrap) divCnt <= '0;
    else              divCnt <= divCnt + 1'b1;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)         holdCnt <= '0;
    else if (!comboHit) holdCnt <= '0;
    else if (!atLimit)  holdCnt <= holdCnt + 1'b1;
  end

  assign strobes.sampleTick = divWrap;
  assign strobes.useFilter  = filtEn;
  assign rstReq             = atLimit & comboHit;

endmodule

// File: rtl/keyin_cond.sv
module keyin_cond
  import keyin_pkg::*;
#(
  parameter int SAMPLE_DIV  = 8,
  parameter int HOLD_CYCLES = 65536
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic [3:0] keyRaw,
  input  logic       filtEn,
  input  logic [1:0] comboSel,
  output logic [3:0] keyLevel,
  output logic [3:0] keyIrq,
  output logic       rstReq
);

  keyStrobes_t strobes;
  logic        comboHit;

  keyin_control #(
    .SAMPLE_DIV (SAMPLE_DIV),
    .HOLD_CYCLES(HOLD_CYCLES)
  ) u_ctrl (
    .clk     (clk),
    .rstN    (rstN),
    .filtEn  (filtEn),
    .comboHit(comboHit),
    .strobes (strobes),
    .rstReq  (rstReq)
  );

  keyin_datapath u_dp (
    .clk     (clk),
    .rstN    (rstN),
    .keyRaw  (keyRaw),
    .strobes (strobes),
    .grpSel  (grpSel_t'(comboSel)),
    .keyLevel(keyLevel),
    .keyIrq  (keyIrq),
    .comboHit(comboHit)
  );

endmodule

// File: rtl/keyin_cond_checker.sv
module keyin_cond_checker (
  input logic       clk,
  input logic       rstN,
  input logic       filtEn,
  input logic [1:0] comboSel,
  input logic [3:0] keyLevel,
  input logic [3:0] keyIrq,
  input logic       rstReq,
  input logic       sampleTick
);

  AST_OFF_SILENT: assert property (@(posedge clk) disable iff (!rstN)
    (comboSel == 2'd0) |-> !rstReq); // R7

  AST_IRQ_SINGLE: assert property (@(posedge clk) disable iff (!rstN)
    (keyIrq != 4'd0) |=> ((keyIrq & $past(keyIrq)) == 4'd0)); // R3

  AST_IRQ_FROM_LOW: assert property (@(posedge clk) disable iff (!rstN)
    (keyIrq != 4'd0) |-> ((keyIrq & $past(keyLevel)) == 4'd0)); // R3

  AST_FILT_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    (filtEn && $past(filtEn) && !$past(sampleTick)) |-> $stable(keyLevel)); // R4

  AST_RST_CFG: assert property (@(posedge clk) disable iff (!rstN)
    $rose(rstReq) |-> (comboSel != 2'd0)); // R6

endmodule

bind keyin_cond keyin_cond_checker u_chk (
  .clk       (clk),
  .rstN      (rstN),
  .filtEn    (filtEn),
  .comboSel  (comboSel),
  .keyLevel  (keyLevel),
  .keyIrq    (keyIrq),
  .rstReq    (rstReq),
  .sampleTick(strobes.sampleTick)
);

// File: tb/keyin_cond_bench.sv
module keyin_cond_bench;

  localparam int DIV  = 8;
  localparam int HOLD = 40;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic [3:0] keyRaw = 4'd0;
  logic       filtEn = 1'b0;
  logic [1:0] comboSel = 2'd0;
  logic [3:0] keyLevel, keyIrq;
  logic       rstReq;

  int total = 0;
  int bad = 0;
  bit done = 0;

  always #2 clk = ~clk;

  keyin_cond #(.SAMPLE_DIV(DIV), .HOLD_CYCLES(HOLD)) u_keyin_cond (
    .clk(clk), .rstN(rstN), .keyRaw(keyRaw), .filtEn(filtEn),
    .comboSel(comboSel), .keyLevel(keyLevel), .keyIrq(keyIrq), .rstReq(rstReq)
  );

  task automatic step(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic check(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic logic [3:0] maskOf(input int sel);
    case (sel)
      1: maskOf = 4'b0011;
      2: maskOf = 4'b0111;
      3: maskOf = 4'b1111;
      default: maskOf = 4'b0000;
    endcase
  endfunction

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      bad++;
      total++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    // R1: reset state
    keyRaw = 4'hF;
    step(3);
    check(keyLevel == 0 && keyIrq == 0 && !rstReq, "R1 in reset", {keyLevel, keyIrq}, 0);
    keyRaw = 4'h0;
    step(3);
    rstN = 1'b1;
    step(1);
    check(keyLevel == 0 && keyIrq == 0 && !rstReq, "R1 after reset", {keyLevel, keyIrq}, 0);

    // R2/R3: direct path, each key and mixed patterns
    for (int p = 1; p < 16; p++) begin
      keyRaw = 4'(p);
      step(1);
      check(keyLevel == 0, "R2 one edge", keyLevel, 0);
      step(1);
      check(keyLevel == 4'(p), "R2 two edges", keyLevel, p);
      check(keyIrq == 4'(p), "R3 pulse", keyIrq, p);
      step(1);
      check(keyIrq == 0 && keyLevel == 4'(p), "R3 single cycle", keyIrq, 0);
      keyRaw = 4'd0;
      step(1);
      check(keyIrq == 0, "R3 fall one", keyIrq, 0);
      step(1);
      check(keyIrq == 0 && keyLevel == 0, "R3 fall no pulse", {keyLevel, keyIrq}, 0);
      step(2);
    end

    // R4/R3: filtered path latency and single pulse per key
    filtEn = 1'b1;
    step(4);
    for (int k = 0; k < 4; k++) begin
      int firstE = 0;
      int pulses = 0;
      keyRaw = 4'(1 << k);
      for (int e = 1; e <= 30; e++) begin
        step(1);
        if (keyLevel[k] && firstE == 0) firstE = e;
        if (keyIrq != 0) pulses += (keyIrq == 4'(1 << k)) ? 1 : 100;
      end
      check(firstE >= DIV + 3 && firstE <= 2 * DIV + 2, "R4 latency", firstE, DIV + 3);
      check(pulses == 1, "R3 filtered pulse count", pulses, 1);
      keyRaw = 4'd0;
      pulses = 0;
      for (int e = 1; e <= 30; e++) begin
        step(1);
        if (keyIrq != 0) pulses++;
      end
      check(pulses == 0 && keyLevel == 0, "R3 filtered fall", pulses, 0);
    end

    // R5: short glitches at every divider phase
    for (int off = 0; off < DIV; off++) begin
      int seen = 0;
      step(off + 1);
      keyRaw = 4'(1 << (off % 4));
      step(3);
      keyRaw = 4'd0;
      for (int e = 0; e < 40; e++) begin
        step(1);
        if (keyLevel != 0 || keyIrq != 0) seen++;
      end
      check(seen == 0, "R5 glitch ignored", seen, 0);
    end

    // R6/R7/R8/R10: sweep selects and patterns
    filtEn = 1'b0;
    for (int sel = 0; sel < 4; sel++) begin
      comboSel = 2'(sel);
      step(2);
      for (int p = 0; p < 16; p++) begin
        logic [3:0] m;
        bit hit;
        m = maskOf(sel);
        hit = (m != 0) && ((4'(p) & m) == m);
        keyRaw = 4'(p);
        if (hit) begin
          int lowKey = 0;
          step(HOLD + 1);
          check(!rstReq, "R8 not early", rstReq, 0);
          step(1);
          check(rstReq, "R8 fires on time", rstReq, 1);
          step(6);
          check(rstReq, "R10 stays held", rstReq, 1);
          for (int b = 3; b >= 0; b--) if (m[b]) lowKey = b;
          keyRaw = 4'(p) & ~4'(1 << (sel == 3 ? 3 : lowKey));
          step(1);
          check(rstReq, "R10 sync delay", rstReq, 1);
          step(1);
          check(!rstReq, "R10 release", rstReq, 0);
        end else begin
          step(HOLD + 8);
          check(!rstReq, sel == 0 ? "R7 off" : "R6 partial group", rstReq, 0);
        end
        keyRaw = 4'd0;
        step(4);
      end
    end

    // R9: interrupted hold restarts
    comboSel = 2'd3;
    keyRaw = 4'hF;
    step(HOLD - 5);
    keyRaw = 4'hB;
    step(3);
    keyRaw = 4'hF;
    step(HOLD + 1);
    check(!rstReq, "R9 restart not early", rstReq, 0);
    step(1);
    check(rstReq, "R9 restart fires", rstReq, 1);
    keyRaw = 4'd0;
    step(4);

    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule